// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block sits beside a processor core and decides when the core leaves its halted low-power state and what it does next. A halt request puts the block to sleep. At that moment it records which interrupt request flags are already raised, and those flags lose the right to wake the core for this sleep. While the block is asleep, two things can wake it: a falling edge on any input-port pin whose wake enable is set, or a newly raised interrupt flag.

On wake the block gives the core a one-cycle wake pulse. With it comes one of two instructions. The first is "vector to interrupt", given when a freshly raised interrupt is enabled, the global interrupt enable is on and the stack has room. Otherwise the core is told to resume at the instruction after the halt. In that case an interrupt that could not be serviced stays visible on the pending output until its enable is set or the stack frees up.

Top module: `wake_ctl`

## Requirements
- R1: After reset, asleep, wake, vector_irq and resume_next are all 0.
- R2: When running, a halt_req sampled on a clock edge makes asleep 1 after that edge. While running, wake never rises, whatever the pins or flags do.
- R3: While asleep, a 1-to-0 change on a pin whose pin_wake_en bit is 1 causes wake after the third clock edge that follows the change. The first two of those edges pass the pin through a two-flop synchronizer. If no interrupt is serviceable, resume_next comes with the wake.
- R4: A 0-to-1 change on any pin does not wake the block, and neither does a falling edge on a pin whose enable bit is 0.
- R5: While asleep, an interrupt flag that was low at halt and then rises causes wake after the next clock edge.
- R6: If the waking flag has its irq_en bit at 1, gie is 1 and stack_full is 0, the wake comes with vector_irq=1 and resume_next=0.
- R7: If the waking flag's irq_en bit is 0, or gie is 0, the wake comes with resume_next=1, and irq_pending stays 1 afterwards.
- R8: If the waking flag is enabled but stack_full is 1, the wake comes with resume_next=1.
- R9: A flag that was already 1 on the edge where halt was accepted cannot wake the block during that sleep. A different flag that rises later still can.
- R10: wake is high for exactly one cycle. It comes with exactly one of vector_irq or resume_next, and asleep is 0 from then on.
- R11: irq_pending is 1 whenever some raised flag cannot be serviced right now, meaning its irq_en bit is 0, gie is 0 or stack_full is 1. It falls as soon as that condition clears.
- R12: When a pin edge and a serviceable interrupt wake the block on the same edge, the interrupt wins and vector_irq is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | PINS | Asynchronous input-port pins |
| pin_wake_en | input | PINS | Per-pin falling-edge wake enable |
| irq_flag | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Per-interrupt enables |
| gie | input | 1 | Global interrupt enable |
| stack_full | input | 1 | No free stack level |
| halt_req | input | 1 | Core executes halt |
| wake | output | 1 | One-cycle wake pulse |
| vector_irq | output | 1 | Take interrupt response (valid with wake) |
| resume_next | output | 1 | Resume after halt (valid with wake) |
| irq_pending | output | 1 | A raised flag cannot currently be serviced |
| asleep | output | 1 | Block is in the low-power state |

## Verification
Random rounds pick the flags that are raised at halt, the per-interrupt enables, gie, stack_full and the flag that rises. These rounds separate the case of a flag blocked at halt from that of a fresh flag, and show whether each fresh flag leads to vectoring or to resuming. Directed pin patterns are also applied: a rising edge, a fall on a disabled pin, and a fall on an enabled pin with its exact latency. These show that only enabled falling edges count and that the synchronizer delay is as stated. A simultaneous pin and interrupt wake shows the priority between the two. Changing the enables after the wake shows how the pending output follows them.

// File: rtl/wake_ctl.sv
module wake_ctl #(
  parameter int PINS = 8,
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] port_in,
  input  logic [PINS-1:0] pin_wake_en,
  input  logic [NIRQ-1:0] irq_flag,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            gie,
  input  logic            stack_full,
  input  logic            halt_req,
  output logic            wake,
  output logic            vector_irq,
  output logic            resume_next,
  output logic            irq_pending,
  output logic            asleep
);
  logic [PINS-1:0] sync1, sync2, prev;
  logic [NIRQ-1:0] blocked;
  logic            sleep_q;

  wire [PINS-1:0] fall     = prev & ~sync2 & pin_wake_en;
  wire [NIRQ-1:0] fresh    = irq_flag & ~blocked;
  wire            can_take = gie & ~stack_full;
  wire            serve    = can_take & (|(fresh & irq_en));
  wire            wake_now = sleep_q & ((|fall) | (|fresh));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1       <= '0;
      sync2       <= '0;
      prev        <= '0;
      blocked     <= '0;
      sleep_q     <= 1'b0;
      wake        <= 1'b0;
      vector_irq  <= 1'b0;
      resume_next <= 1'b0;
    end else begin
      sync1       <= port_in;
      sync2       <= sync1;
      prev        <= sync2;
      wake        <= wake_now;
      vector_irq  <= wake_now & serve;
      resume_next <= wake_now & ~serve;
      if (!sleep_q && halt_req) begin
        sleep_q <= 1'b1;
        blocked <= irq_flag;
      end else if (wake_now) begin
        sleep_q <= 1'b0;
        blocked <= '0;
      end
    end
  end

  assign asleep      = sleep_q;
  assign irq_pending = |(irq_flag & ~({NIRQ{can_take}} & irq_en));

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && halt_req) |=> asleep);
  p_no_run_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !halt_req) |=> !wake);
  p_vector_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vector_irq |-> $past(gie && !stack_full));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($countones({vector_irq, resume_next}) == 1 && !asleep));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |-> (!vector_irq && !resume_next));
endmodule

// File: tb/test_wake_ctl.sv
module test_wake_ctl;
  localparam int PINS = 8;
  localparam int NIRQ = 4;

  logic clk = 0, rst_n = 0;
  logic [PINS-1:0] port_in = '1, pin_wake_en = '0;
  logic [NIRQ-1:0] irq_flag = '0, irq_en = '0;
  logic gie = 0, stack_full = 0, halt_req = 0;
  logic wake, vector_irq, resume_next, irq_pending, asleep;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wake_ctl #(.PINS(PINS), .NIRQ(NIRQ)) i_wake_ctl (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .pin_wake_en(pin_wake_en),
    .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .stack_full(stack_full),
    .halt_req(halt_req), .wake(wake), .vector_irq(vector_irq),
    .resume_next(resume_next), .irq_pending(irq_pending), .asleep(asleep));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_vec(input logic [NIRQ-1:0] f, input logic [NIRQ-1:0] en,
                                   input logic g, input logic sf);
    return g && !sf && (|(f & en));
  endfunction

  function automatic logic exp_pend(input logic [NIRQ-1:0] f, input logic [NIRQ-1:0] en,
                                    input logic g, input logic sf);
    return |(f & ~({NIRQ{g && !sf}} & en));
  endfunction

  task automatic go_sleep();
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    chk("R2 asleep after halt", asleep, 1);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_wake(input int b);
    port_in[b] = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no wake before sync", wake, 0);
    @(negedge clk);
    chk("R3 pin wake on third edge", wake, 1);
    chk("R3 resume with pin wake", resume_next, 1);
    @(negedge clk);
    chk("R10 wake one cycle", wake, 0);
    chk("R10 running after wake", asleep, 0);
    port_in[b] = 1;
    settle(4);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'h5eed_1234));
    settle(3);
    chk("R1 asleep reset", asleep, 0);
    chk("R1 wake reset", wake, 0);
    chk("R1 vector reset", vector_irq, 0);
    chk("R1 resume reset", resume_next, 0);
    rst_n = 1;
    settle(4);

    // R2: while running, flags and pin edges do not wake
    pin_wake_en = 8'h01;
    irq_flag = 4'h1;
    port_in[0] = 0;
    seen = 0;
    repeat (5) begin @(negedge clk); seen += wake; end
    chk("R2 no wake while running", seen, 0);
    irq_flag = 0; port_in[0] = 1; settle(4);

    // R4: rising edges and disabled-pin falls are ignored
    port_in = 8'hfe; settle(4);
    go_sleep();
    port_in[0] = 1;
    port_in[5] = 0;
    seen = 0;
    repeat (6) begin @(negedge clk); seen += wake; end
    chk("R4 rising/disabled ignored", seen, 0);
    chk("R4 still asleep", asleep, 1);
    port_in[5] = 1;
    settle(2);
    pin_wake(0);

    // R9 and R7: blocked flag, then a fresh disabled flag
    irq_flag = 4'h2;
    go_sleep();
    irq_flag = 4'h0; @(negedge clk);
    irq_flag = 4'h2;
    seen = 0;
    repeat (4) begin @(negedge clk); seen += wake; end
    chk("R9 blocked flag no wake", seen, 0);
    irq_en = 4'h0; gie = 1;
    irq_flag = 4'h6;
    @(negedge clk);
    chk("R9 fresh flag wakes", wake, 1);
    chk("R7 disabled resumes", resume_next, 1);
    chk("R7 pending stays", irq_pending, 1);
    irq_en = 4'h6;
    #1;
    chk("R11 pending falls when enabled", irq_pending, 0);
    stack_full = 1;
    #1;
    chk("R11 pending on stack full", irq_pending, 1);
    stack_full = 0;
    irq_flag = 0; irq_en = 0; settle(2);

    // R8: stack full
    irq_en = 4'h8; gie = 1; stack_full = 1;
    go_sleep();
    irq_flag = 4'h8;
    @(negedge clk);
    chk("R8 wake", wake, 1);
    chk("R8 resume on stack full", resume_next, 1);
    chk("R8 no vector", vector_irq, 0);
    stack_full = 0; #1;
    chk("R11 pending clears when stack frees", irq_pending, 0);
    irq_flag = 0; settle(2);

    // R12: pin and serviceable irq on the same edge
    go_sleep();
    port_in[0] = 0;
    @(negedge clk);
    @(negedge clk);
    irq_flag = 4'h8;
    @(negedge clk);
    chk("R12 wake", wake, 1);
    chk("R12 interrupt wins", vector_irq, 1);
    port_in[0] = 1; irq_flag = 0; settle(4);

    // random rounds: R5 R6 R7 R8 R9
    for (int it = 0; it < 60; it++) begin
      logic [NIRQ-1:0] pre, en;
      logic g, sf;
      int k;
      pre = NIRQ'($urandom);
      en = NIRQ'($urandom);
      g = 1'($urandom);
      sf = 1'($urandom);
      k = $urandom_range(NIRQ-1, 0);
      irq_flag = pre; irq_en = en; gie = g; stack_full = sf;
      go_sleep();
      irq_flag[k] = 1;
      @(negedge clk);
      if (pre[k]) begin
        chk("R9 random blocked", wake, 0);
        pin_wake(0);
      end else begin
        chk("R5 random wake", wake, 1);
        chk("R6 random vector", vector_irq, exp_vec(irq_flag & ~pre, en, g, sf));
        chk("R7 random resume", resume_next, !exp_vec(irq_flag & ~pre, en, g, sf));
        chk("R11 random pending", irq_pending, exp_pend(irq_flag, en, g, sf));
        @(negedge clk);
        chk("R10 random pulse", wake, 0);
      end
      irq_flag = 0;
      settle(2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule